// File: doc/BRIEF.md
# Lock-Qualified Processor Reset Stretcher

This block produces a processor reset line that also tells the board whether the clock generator has locked. It runs on the system clock at the output frequency of the clock generator. It watches two things: a lock flag from the PLL model and an active-low reset request from the board. The line is held low until both the lock flag and the request are high. It then stays low for a fixed number of further clock cycles (1024 by default) and is finally let go.

The output behaves like an open-drain pin. The block never drives it high. It either pulls it low or leaves it floating, and an external pull-up is assumed to take a floating line high. Two signals carry this out of the block: an enable for the low-side driver, and the level the board would see.

Both asynchronous inputs pass through synchronizer flops before they reach the stretch counter. Whenever either qualifying condition drops, the counter restarts from zero. So losing lock, or a new reset request, always gives a full-length reset once conditions return.

Top module: `lockrst_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets itself and `pull_low_en` is high after that edge.
- R2: With `rst_req_n` high and `pll_locked` low, `pull_low_en` stays high for any length of time.
- R3: When `pll_locked` rises while `rst_req_n` is high, `pull_low_en` falls at exactly rising edge number SYNC_STAGES+HOLD_CYCLES after the change (edge 1026 with the defaults). It is still high one edge earlier.
- R4: While `rst_req_n` is held low from reset onward, `pull_low_en` stays high even after `pll_locked` rises. It falls SYNC_STAGES+HOLD_CYCLES edges after `rst_req_n` goes high.
- R5: When `rst_req_n` goes low after release, `pull_low_en` rises at edge SYNC_STAGES+1 after the change and not earlier. After `rst_req_n` returns high, the full count runs again, as in R3.
- R6: When `pll_locked` drops after release, `pull_low_en` rises at edge SYNC_STAGES+1 after the change. On return of lock, the full count restarts, even when lock was missing for only one cycle.
- R7: Open-drain output. `rst_level` is 0 exactly when `pull_low_en` is 1 and is 1 exactly when it is 0. The block never actively drives the line high.
- R8: Once released, the line stays released for as long as both `rst_req_n` and `pll_locked` stay high. The counter holds at its terminal value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at the output frequency of the clock generator |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rst_req_n | input | 1 | Asynchronous active-low reset request from the board |
| pll_locked | input | 1 | Asynchronous lock flag from the PLL model, high when locked |
| pull_low_en | output | 1 | 1 = low-side driver on (line pulled low), 0 = line floating |
| rst_level | output | 1 | Level the line settles to with the external pull-up |

## Verification
The stretch is exercised along three routes to release: lock arriving after power-up, a reset request being released, and lock returning after a loss. Each route is timed to the exact edge, which separates a correct synchronizer-plus-counter latency from off-by-one errors in either stage. A one-cycle lock dropout tells a counter that restarts apart from one that merely pauses. A request held low through lock shows that lock alone cannot release the line. A long wait after release shows that the counter saturates rather than wrapping.

// File: rtl/lockrst_pkg.sv
// lockrst_pkg: shared defaults and types for the lock-qualified reset stretcher.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lockrst_pkg;
    localparam int LOCKRST_HOLD_DEFAULT = 1024;
    localparam int LOCKRST_SYNC_DEFAULT = 2;

    // Bundle of the two asynchronous qualifiers, kept together through the synchronizer.
    typedef struct packed {
        logic req_ok;   // reset request released (high)
        logic locked;   // PLL reports lock
    } qual_t;
endpackage

// File: rtl/lockrst_sync.sv
// lockrst_sync: multi-flop synchronizer for a vector of asynchronous levels.
// Assumes the inputs are quasi-static levels; each bit is synchronized on its own.
// Reset value of every stage is 0, so the qualifiers read "not ready" after reset.
module lockrst_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/lockrst_stretch.sv
// lockrst_stretch: saturating stretch counter with a registered release flag.
// Assumes `qual` is synchronous to clk. The counter clears whenever qual is low.
// It climbs to HOLD_CYCLES-1 and parks there. The release flag sets one edge
// after the terminal value is seen with qual still high.
module lockrst_stretch #(
    parameter int HOLD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic released
);
    localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] TERM = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          at_term;

    assign at_term = (cnt_q == TERM);

    // Counter: clear when not qualified, else count up and hold at terminal.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!qual)    cnt_q <= '0;
        else if (!at_term) cnt_q <= cnt_q + 1'b1;
    end

    // Release flag: set only while qualified and the count has completed.
    always_ff @(posedge clk) begin
        if (!rst_n) released <= 1'b0;
        else        released <= qual && at_term;
    end
endmodule

// File: rtl/lockrst_seq.sv
// lockrst_seq: open-drain style processor reset that doubles as a lock flag.
// Assumes clk is the system output-rate clock and rst_n is a synchronous
// power-on reset. The line is pulled low until both the request and lock
// are high and the stretch count has run. It is never driven high.
module lockrst_seq
    import lockrst_pkg::*;
#(
    parameter int HOLD_CYCLES = LOCKRST_HOLD_DEFAULT,
    parameter int SYNC_STAGES = LOCKRST_SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req_n,
    input  logic pll_locked,
    output logic pull_low_en,
    output logic rst_level
);
    localparam int QW = $bits(qual_t);

    qual_t raw_q, syn_q;
    logic  qual_ok;
    logic  released;

    // Gather the asynchronous qualifiers into one bundle.
    always_comb begin
        raw_q.req_ok = rst_req_n;
        raw_q.locked = pll_locked;
    end

    lockrst_sync #(
        .WIDTH  (QW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_q),
        .sync_out (syn_q)
    );

    // Both conditions must hold for the stretch to progress.
    assign qual_ok = syn_q.req_ok && syn_q.locked;

    lockrst_stretch #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual_ok),
        .released (released)
    );

    // Open-drain model: drive low until released, then float to the pull-up.
    assign pull_low_en = !released;
    assign rst_level   = pull_low_en ? 1'b0 : 1'b1;
endmodule

// File: rtl/lockrst_seq_chk.sv
// lockrst_seq_chk: temporal checks for lockrst_seq, attached by bind.
// Assumes the same parameters as the bound instance.
module lockrst_seq_chk #(
    parameter int HOLD_CYCLES = 1024,
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic rst_req_n,
    input logic pll_locked,
    input logic pull_low_en,
    input logic rst_level
);
    localparam int RW = $clog2(HOLD_CYCLES + SYNC_STAGES + 4) + 1;
    localparam logic [RW-1:0] RMAX = RW'(HOLD_CYCLES + SYNC_STAGES + 2);

    logic [RW-1:0] run_q;

    // Length of the current run with both inputs high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        run_q <= '0;
        else if (!(rst_req_n && pll_locked)) run_q <= '0;
        else if (run_q != RMAX)            run_q <= run_q + 1'b1;
    end

    AST_LOW_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low_en |-> !rst_level);                                      // R7
    AST_HIGH_ONLY_FLOATING: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_low_en |-> rst_level);                                      // R7
    AST_REQUEST_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n |-> ##(SYNC_STAGES+1) pull_low_en);                    // R5
    AST_LOCKLOSS_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |-> ##(SYNC_STAGES+1) pull_low_en);                   // R6
    AST_RELEASE_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low_en) |-> (run_q >= RW'(HOLD_CYCLES)));              // R3
    AST_STAYS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pull_low_en && rst_req_n && pll_locked && $past(rst_req_n) && $past(pll_locked)
         && $past(rst_req_n, 2) && $past(pll_locked, 2)
         && $past(rst_req_n, 3) && $past(pll_locked, 3)) |=> !pull_low_en); // R8
endmodule

bind lockrst_seq lockrst_seq_chk #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_req_n   (rst_req_n),
    .pll_locked  (pll_locked),
    .pull_low_en (pull_low_en),
    .rst_level   (rst_level)
);

// File: tb/lockrst_seq_test.sv
`timescale 1ns/1ps
// lockrst_seq_test: scoreboard bench. The driver queues expected line states
// for given cycle numbers; the monitor compares them at falling edges.
module lockrst_seq_test;
    localparam int HOLD = 1024;
    localparam int SYNC = 2;
    localparam int LAT  = HOLD + SYNC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req_n = 1'b1;
    logic pll_locked = 1'b0;
    logic pull_low_en, rst_level;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    low;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lockrst_seq #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .rst_req_n(rst_req_n), .pll_locked(pll_locked),
        .pull_low_en(pull_low_en), .rst_level(rst_level)
    );

    task automatic expect_at(input int dc, input bit low, input string tag);
        exp_t e;
        e.at = cyc + dc; e.low = low; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: pop and compare expectations due at this cycle.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.at < cyc || pull_low_en !== e.low) begin
                    failures++;
                    $display("FAIL %s cyc=%0d pull_low_en actual=%b expected=%b",
                             e.tag, cyc, pull_low_en, e.low);
                end
                checks++;
                if (rst_level !== !e.low) begin
                    failures++;
                    $display("FAIL R7 (%s) cyc=%0d rst_level actual=%b expected=%b",
                             e.tag, cyc, rst_level, !e.low);
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            finish_run();
        end
    end

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        expect_at(1, 1'b1, "R1 during reset");
        drain();
        rst_n = 1'b1;
        expect_at(1, 1'b1, "R1 after reset");
        expect_at(40, 1'b1, "R2 unlocked");
        drain();

        pll_locked = 1'b1;
        expect_at(LAT - 1, 1'b1, "R3 before release");
        expect_at(LAT, 1'b0, "R3 release");
        drain();
        expect_at(3000, 1'b0, "R8 stays released");
        drain();

        rst_req_n = 1'b0;
        expect_at(SYNC, 1'b0, "R5 not yet asserted");
        expect_at(SYNC + 1, 1'b1, "R5 asserted");
        expect_at(10, 1'b1, "R5 held");
        drain();
        rst_req_n = 1'b1;
        expect_at(LAT - 1, 1'b1, "R5 before release");
        expect_at(LAT, 1'b0, "R5 release");
        drain();

        pll_locked = 1'b0;
        expect_at(SYNC, 1'b0, "R6 not yet asserted");
        expect_at(SYNC + 1, 1'b1, "R6 asserted");
        expect_at(8, 1'b1, "R6 held");
        drain();
        pll_locked = 1'b1;
        expect_at(LAT - 1, 1'b1, "R6 before release");
        expect_at(LAT, 1'b0, "R6 release");
        drain();

        pll_locked = 1'b0;
        @(negedge clk);
        pll_locked = 1'b1;
        expect_at(2, 1'b1, "R6 brief loss asserted");
        expect_at(LAT - 1, 1'b1, "R6 brief loss full restart");
        expect_at(LAT, 1'b0, "R6 brief loss release");
        drain();

        rst_n = 1'b0;
        rst_req_n = 1'b0;
        pll_locked = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_at(5, 1'b1, "R4 after reset");
        drain();
        pll_locked = 1'b1;
        expect_at(1100, 1'b1, "R4 request low");
        expect_at(1500, 1'b1, "R4 request still low");
        drain();
        rst_req_n = 1'b1;
        expect_at(LAT - 1, 1'b1, "R4 before release");
        expect_at(LAT, 1'b0, "R4 release");
        drain();

        done = 1'b1;
        finish_run();
    end
endmodule